// File: doc/BRIEF.md
# Exception Dispatch Unit

This block sits beside a processor pipeline and turns exception requests into a
control-flow redirect and a consistent update of the processor's status and
save registers. The pipeline presents a general exception with its program
counter, a cause code and, when the fault concerns memory, the faulting virtual
address. A separate port carries debug exceptions with their own PC and cause.
A debug request is either unconditional (for example a breakpoint) or raised by
the environment. An environment request only goes ahead when the current
interrupt level is below the configured debug level.

For each accepted request the block picks a vector code: kernel, user, double or
debug. It updates the status word and the save registers, then pulses a redirect
strobe with that code for one cycle. An exception that arrives while the
exception-mode bit is already set is a nested fault. It goes to the double
vector, and its PC is saved either in a dedicated double-exception PC register or
in the level-1 PC register, depending on a configuration input. Debug entry saves
the old status word into a status save slot indexed by the debug level, and
raises the interrupt level to that value.

The pipeline also uses a status load port to write the status word directly, for
example to leave exception mode. Return-from-exception sequencing, vector
address tables and interrupt arbitration belong to other blocks.

Top module: `exc_dispatch`

## Requirements
- R1: After reset every register output (status, all PC and status save slots, cause, fault address, debug cause, vector code) is zero and `redirect_o` is low.
- R2: A general exception accepted with status EXCM (bit 4) clear and UM (bit 5) clear selects vector code 0 (kernel). It writes its PC into the level-1 PC slot. `redirect_o` is high in the cycle after the request.
- R3: A general exception accepted with EXCM clear and UM set selects vector code 1 (user) and writes its PC into the level-1 PC slot.
- R4: A general exception accepted with EXCM already set selects vector code 2 (double). Its PC goes to `depc_o` and leaves the level-1 slot unchanged when `cfg_has_depc` is 1. Otherwise it goes to the level-1 slot.
- R5: Every accepted general exception writes its cause into `exccause_o` and sets EXCM. The interrupt level (status bits 3:0) and UM are left unchanged.
- R6: An accepted general exception with `exc_addr_vld` set writes `exc_addr` into `excvaddr_o`. Without that flag, `excvaddr_o` keeps its value.
- R7: An accepted debug exception selects vector code 3. It writes its cause into `dbgcause_o`, its PC into the PC slot of level `cfg_dbg_level`, and the old status word into the status save slot of that level. It sets the interrupt level to `cfg_dbg_level` and sets EXCM, keeping UM. It leaves `exccause_o` unchanged.
- R8: A debug request with `dbg_env` set is dropped when the interrupt level is greater than or equal to `cfg_dbg_level`. A dropped request gives no redirect and changes no register.
- R9: When an accepted debug request and a general exception arrive in the same cycle, only the debug exception is processed. When the debug request is dropped, the general exception is processed as if alone.
- R10: `redirect_o` is high for exactly one cycle per accepted request and low in a cycle after no request. With no request, `ps_wr_en` loads `ps_wr_data` into the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_has_depc | input | 1 | Nested-fault PC goes to the dedicated register when 1 |
| cfg_dbg_level | input | 4 | Interrupt level used for debug entry (2..NLEVELS) |
| ps_wr_en | input | 1 | Load the status word |
| ps_wr_data | input | 6 | Status value: [3:0] level, [4] EXCM, [5] UM |
| exc_req | input | 1 | General exception request |
| exc_pc | input | XLEN | PC of the faulting instruction |
| exc_cause | input | CAUSE_W | Exception cause code |
| exc_addr_vld | input | 1 | Request carries a faulting address |
| exc_addr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_env | input | 1 | Debug request is raised by the environment (level-gated) |
| dbg_pc | input | XLEN | PC for the debug exception |
| dbg_cause | input | CAUSE_W | Debug cause bits |
| redirect_o | output | 1 | One-cycle redirect strobe |
| vector_o | output | 3 | Vector code: 0 kernel, 1 user, 2 double, 3 debug |
| ps_o | output | 6 | Status word |
| epc_o | output | NLEVELS*XLEN | PC save slots, level l at bits [(l-1)*XLEN +: XLEN] |
| eps_o | output | (NLEVELS-1)*6 | Status save slots, level l at bits [(l-2)*6 +: 6] |
| depc_o | output | XLEN | Double-exception PC |
| exccause_o | output | CAUSE_W | Last general exception cause |
| excvaddr_o | output | XLEN | Last faulting virtual address |
| dbgcause_o | output | CAUSE_W | Last debug cause |

## Verification
Every result here is registered once. A request driven before edge N shows up on
`redirect_o`, `vector_o` and every save register right after edge N, so the bench
samples at the following falling edge. The strobe has to be low again one cycle
later. Each table row first loads the status word, then applies the request for a
single cycle, then compares all affected outputs together. For that comparison it
uses the values captured just before the request to check the registers that must
keep their value. The drop rule is checked with both an equal and a greater
interrupt level, and the tie-break with both an accepted and a dropped debug
request.

// File: rtl/exc_disp_pkg.sv
package exc_disp_pkg;
   localparam int PS_LVL_W = 4;
   localparam int PS_W     = PS_LVL_W + 2;

   typedef struct packed {
      logic                um;
      logic                excm;
      logic [PS_LVL_W-1:0] intlevel;
   } ps_t;

   typedef enum logic [2:0] {
      VEC_KERNEL = 3'd0,
      VEC_USER   = 3'd1,
      VEC_DOUBLE = 3'd2,
      VEC_DEBUG  = 3'd3
   } vec_e;
endpackage

// File: rtl/exc_disp_arb.sv
module exc_disp_arb
   import exc_disp_pkg::*;
(
   input  ps_t                 ps_cur,
   input  logic                exc_req,
   input  logic                dbg_req,
   input  logic                dbg_env,
   input  logic [PS_LVL_W-1:0] dbg_level,
   input  logic                has_depc,
   output logic                dbg_take,
   output logic                exc_take,
   output vec_e                vec_sel,
   output logic                gen_to_depc,
   output logic                gen_to_epc1
);
   logic dbg_allowed;

   always_comb begin
      dbg_allowed = !dbg_env || (ps_cur.intlevel < dbg_level);
      dbg_take    = dbg_req && dbg_allowed;
      exc_take    = exc_req && !dbg_take;
      if (dbg_take)          vec_sel = VEC_DEBUG;
      else if (ps_cur.excm)  vec_sel = VEC_DOUBLE;
      else if (ps_cur.um)    vec_sel = VEC_USER;
      else                   vec_sel = VEC_KERNEL;
      gen_to_depc = exc_take && ps_cur.excm && has_depc;
      gen_to_epc1 = exc_take && !(ps_cur.excm && has_depc);
   end
endmodule

// File: rtl/exc_disp_bank.sv
module exc_disp_bank
   import exc_disp_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int NLEVELS = 6
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         epc_we,
   input  logic [PS_LVL_W-1:0]          epc_lvl,
   input  logic [XLEN-1:0]              epc_data,
   input  logic                         eps_we,
   input  logic [PS_LVL_W-1:0]          eps_lvl,
   input  logic [PS_W-1:0]              eps_data,
   output logic [NLEVELS*XLEN-1:0]      epc_flat,
   output logic [(NLEVELS-1)*PS_W-1:0]  eps_flat
);
   for (genvar l = 1; l <= NLEVELS; l++) begin : g_epc
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 q <= '0;
         else if (epc_we && (int'(epc_lvl) == l))    q <= epc_data;
      end
      assign epc_flat[(l-1)*XLEN +: XLEN] = q;
   end

   for (genvar l = 2; l <= NLEVELS; l++) begin : g_eps
      logic [PS_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 q <= '0;
         else if (eps_we && (int'(eps_lvl) == l))    q <= eps_data;
      end
      assign eps_flat[(l-2)*PS_W +: PS_W] = q;
   end

   // R7: status save slots move only on a debug entry
   a_r7_eps_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !eps_we |=> $stable(eps_flat));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
   import exc_disp_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CAUSE_W   = 6,
   parameter int NLEVELS   = 6,
   parameter bit DEPC_IMPL = 1'b1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_has_depc,
   input  logic [3:0]                   cfg_dbg_level,
   input  logic                         ps_wr_en,
   input  logic [5:0]                   ps_wr_data,
   input  logic                         exc_req,
   input  logic [XLEN-1:0]              exc_pc,
   input  logic [CAUSE_W-1:0]           exc_cause,
   input  logic                         exc_addr_vld,
   input  logic [XLEN-1:0]              exc_addr,
   input  logic                         dbg_req,
   input  logic                         dbg_env,
   input  logic [XLEN-1:0]              dbg_pc,
   input  logic [CAUSE_W-1:0]           dbg_cause,
   output logic                         redirect_o,
   output logic [2:0]                   vector_o,
   output logic [5:0]                   ps_o,
   output logic [NLEVELS*XLEN-1:0]      epc_o,
   output logic [(NLEVELS-1)*6-1:0]     eps_o,
   output logic [XLEN-1:0]              depc_o,
   output logic [CAUSE_W-1:0]           exccause_o,
   output logic [XLEN-1:0]              excvaddr_o,
   output logic [CAUSE_W-1:0]           dbgcause_o
);
   localparam int MAX_LVL = (1 << PS_LVL_W) - 1;

   if (NLEVELS < 2 || NLEVELS > MAX_LVL) begin : g_bad_levels
      $error("NLEVELS must lie in 2..%0d", MAX_LVL);
   end
   if (XLEN < 8 || CAUSE_W < 1) begin : g_bad_width
      $error("XLEN must be at least 8 and CAUSE_W at least 1");
   end
   if (PS_W != 6) begin : g_bad_ps
      $error("status word port assumes 6 bits");
   end

   ps_t  ps_q;
   vec_e vec_sel, vec_q;
   logic dbg_take, exc_take, gen_to_depc, gen_to_epc1;
   logic redirect_q;
   logic [CAUSE_W-1:0] exccause_q, dbgcause_q;
   logic [XLEN-1:0]    excvaddr_q;

   exc_disp_arb u_arb (
      .ps_cur      (ps_q),
      .exc_req     (exc_req),
      .dbg_req     (dbg_req),
      .dbg_env     (dbg_env),
      .dbg_level   (cfg_dbg_level),
      .has_depc    (cfg_has_depc && DEPC_IMPL),
      .dbg_take    (dbg_take),
      .exc_take    (exc_take),
      .vec_sel     (vec_sel),
      .gen_to_depc (gen_to_depc),
      .gen_to_epc1 (gen_to_epc1)
   );

   // PC save slot: level 1 for general faults, debug level for debug entry
   logic                epc_we;
   logic [PS_LVL_W-1:0] epc_lvl;
   logic [XLEN-1:0]     epc_data;

   always_comb begin
      epc_we   = dbg_take || gen_to_epc1;
      epc_lvl  = dbg_take ? cfg_dbg_level : PS_LVL_W'(1);
      epc_data = dbg_take ? dbg_pc : exc_pc;
   end

   exc_disp_bank #(.XLEN(XLEN), .NLEVELS(NLEVELS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .epc_we   (epc_we),
      .epc_lvl  (epc_lvl),
      .epc_data (epc_data),
      .eps_we   (dbg_take),
      .eps_lvl  (cfg_dbg_level),
      .eps_data (ps_q),
      .epc_flat (epc_o),
      .eps_flat (eps_o)
   );

   if (DEPC_IMPL) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           depc_q <= '0;
         else if (gen_to_depc) depc_q <= exc_pc;
      end
      assign depc_o = depc_q;
   end else begin : g_no_depc
      assign depc_o = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q       <= '0;
         exccause_q <= '0;
         excvaddr_q <= '0;
         dbgcause_q <= '0;
         redirect_q <= 1'b0;
         vec_q      <= VEC_KERNEL;
      end else begin
         redirect_q <= dbg_take || exc_take;
         if (dbg_take || exc_take) vec_q <= vec_sel;
         if (dbg_take) begin
            ps_q.intlevel <= cfg_dbg_level;
            ps_q.excm     <= 1'b1;
            dbgcause_q    <= dbg_cause;
         end else if (exc_take) begin
            ps_q.excm  <= 1'b1;
            exccause_q <= exc_cause;
            if (exc_addr_vld) excvaddr_q <= exc_addr;
         end else if (ps_wr_en) begin
            ps_q <= ps_t'(ps_wr_data);
         end
      end
   end

   assign redirect_o = redirect_q;
   assign vector_o   = vec_q;
   assign ps_o       = ps_q;
   assign exccause_o = exccause_q;
   assign excvaddr_o = excvaddr_q;
   assign dbgcause_o = dbgcause_q;

   // R5: any redirect leaves the block in exception mode
   a_r5_excm_after: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> ps_o[4]);

   // R4: a lone general fault in exception mode goes to the double vector
   a_r4_nested: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !dbg_req && ps_o[4]) |=> (redirect_o && vector_o == 3'd2));

   // R7: debug entry raises the level to the configured debug level
   a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && !dbg_env) |=> (vector_o == 3'd3 && ps_o[3:0] == $past(cfg_dbg_level)));

   // R8: a level-gated debug request is dropped at or above the debug level
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && dbg_env && !exc_req && ps_o[3:0] >= cfg_dbg_level) |=> !redirect_o);

   // R10: no request, no redirect
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && !dbg_req) |=> !redirect_o);

   // R6: fault address register moves only with a flagged general request
   a_r6_vaddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_req && exc_addr_vld) |=> $stable(excvaddr_o));
endmodule

// File: tb/exc_dispatch_tb.sv
`timescale 1ns/1ps
module exc_dispatch_tb;
   localparam int XLEN = 32;
   localparam int CW   = 6;
   localparam int NL   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            cfg_has_depc = 1'b0;
   logic [3:0]      cfg_dbg_level = 4'd3;
   logic            ps_wr_en = 1'b0;
   logic [5:0]      ps_wr_data = '0;
   logic            exc_req = 1'b0, exc_addr_vld = 1'b0;
   logic [XLEN-1:0] exc_pc = '0, exc_addr = '0, dbg_pc = '0;
   logic [CW-1:0]   exc_cause = '0, dbg_cause = '0;
   logic            dbg_req = 1'b0, dbg_env = 1'b0;
   logic            redirect_o;
   logic [2:0]      vector_o;
   logic [5:0]      ps_o;
   logic [NL*XLEN-1:0]   epc_o;
   logic [(NL-1)*6-1:0]  eps_o;
   logic [XLEN-1:0] depc_o, excvaddr_o;
   logic [CW-1:0]   exccause_o, dbgcause_o;

   exc_dispatch #(.XLEN(XLEN), .CAUSE_W(CW), .NLEVELS(NL)) u_dut (.*);

   int total = 0, bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic chkv(input string req, input logic [63:0] act, input logic [63:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   typedef struct packed {
      logic [5:0]  ps;
      logic        depc;
      logic        dbg;
      logic        env;
      logic        gen;
      logic [3:0]  lvl;
      logic [31:0] pc;
      logic [5:0]  cause;
      logic        av;
      logic [31:0] addr;
      logic [2:0]  ev;
      logic        er;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 32'h0000_1000, 6'd5,  1'b1, 32'hDEAD_0010, 3'd0, 1'b1}, // R2 R6
      '{6'h20, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 32'h0000_2004, 6'd9,  1'b0, 32'h1111_1111, 3'd1, 1'b1}, // R3 R6
      '{6'h12, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 32'h0000_3008, 6'd12, 1'b0, 32'h0,         3'd2, 1'b1}, // R4 depc
      '{6'h30, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 32'h0000_400C, 6'd3,  1'b1, 32'hBEEF_0020, 3'd2, 1'b1}, // R4 epc1
      '{6'h02, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 32'h0000_5010, 6'd1,  1'b0, 32'h0,         3'd3, 1'b1}, // R7
      '{6'h05, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 32'h0000_6014, 6'd2,  1'b0, 32'h0,         3'd0, 1'b0}, // R8 above
      '{6'h21, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4, 32'h0000_7018, 6'd4,  1'b1, 32'hCAFE_0030, 3'd3, 1'b1}, // R9 debug wins
      '{6'h04, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4, 32'h0000_801C, 6'd7,  1'b1, 32'hF00D_0040, 3'd0, 1'b1}, // R9 dropped, R8 equal
      '{6'h13, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 32'h0000_9020, 6'd8,  1'b0, 32'h0,         3'd3, 1'b1}, // R7 level 6
      '{6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 32'h0000_A024, 6'd16, 1'b0, 32'h0,         3'd3, 1'b1}  // R7 level 2
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chkv("R1 redirect", redirect_o, 0);
      chkv("R1 ps", ps_o, 0);
      chkv("R1 epc", epc_o[63:0], 0);
      chkv("R1 vector", vector_o, 0);
      chkv("R1 cause", exccause_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v = TBL[i];
         logic [CW-1:0]   cause_b;
         logic [XLEN-1:0] vaddr_b, epc1_b, depc_b, pc_b;
         logic [5:0]      ps_b;
         logic [CW-1:0]   dbgc_b;
         // load status word
         ps_wr_en = 1'b1; ps_wr_data = v.ps;
         @(negedge clk);
         ps_wr_en = 1'b0;
         chkv("R10 ps load", ps_o, v.ps);
         cause_b = exccause_o; vaddr_b = excvaddr_o; epc1_b = epc_o[31:0];
         depc_b = depc_o; ps_b = ps_o; dbgc_b = dbgcause_o;
         pc_b = epc_o[(v.lvl-1)*32 +: 32];
         cfg_has_depc = v.depc; cfg_dbg_level = v.lvl;
         exc_req = v.gen; exc_pc = v.pc; exc_cause = v.cause;
         exc_addr_vld = v.av; exc_addr = v.addr;
         dbg_req = v.dbg; dbg_env = v.env;
         dbg_pc = v.pc ^ 32'h8000_0000; dbg_cause = v.cause ^ 6'h20;
         @(negedge clk);
         exc_req = 1'b0; dbg_req = 1'b0; exc_addr_vld = 1'b0;
         chkv("R10 redirect", redirect_o, v.er);
         if (v.er) chkv("R2 R3 R4 R7 vector", vector_o, v.ev);
         if (!v.er) begin
            chkv("R8 ps kept", ps_o, ps_b);
            chkv("R8 dbgcause kept", dbgcause_o, dbgc_b);
            chkv("R8 epc kept", epc_o[(v.lvl-1)*32 +: 32], pc_b);
         end else if (v.ev == 3'd3) begin
            chkv("R7 epc slot", epc_o[(v.lvl-1)*32 +: 32], v.pc ^ 32'h8000_0000);
            chkv("R7 eps slot", eps_o[(v.lvl-2)*6 +: 6], v.ps);
            chkv("R7 ps", ps_o, {v.ps[5], 1'b1, v.lvl});
            chkv("R7 dbgcause", dbgcause_o, v.cause ^ 6'h20);
            chkv("R7 R9 exccause kept", exccause_o, cause_b);
            chkv("R9 excvaddr kept", excvaddr_o, vaddr_b);
         end else begin
            chkv("R5 exccause", exccause_o, v.cause);
            chkv("R5 ps", ps_o, v.ps | 6'h10);
            if (v.av) chkv("R6 excvaddr", excvaddr_o, v.addr);
            else      chkv("R6 excvaddr kept", excvaddr_o, vaddr_b);
            if (v.ev == 3'd2 && v.depc) begin
               chkv("R4 depc", depc_o, v.pc);
               chkv("R4 epc1 kept", epc_o[31:0], epc1_b);
            end else begin
               chkv("R2 R3 R4 epc1", epc_o[31:0], v.pc);
               chkv("R4 depc kept", depc_o, depc_b);
            end
         end
         @(negedge clk);
         chkv("R10 strobe falls", redirect_o, 0);
      end

      // R10: back-to-back requests give two strobes, then idle
      ps_wr_en = 1'b1; ps_wr_data = 6'h00;
      @(negedge clk);
      ps_wr_en = 1'b0;
      exc_req = 1'b1; exc_pc = 32'h0000_B000; exc_cause = 6'd11;
      @(negedge clk);
      chkv("R10 first strobe", redirect_o, 1);
      chkv("R2 first vector", vector_o, 0);
      exc_pc = 32'h0000_B004;
      @(negedge clk);
      exc_req = 1'b0;
      chkv("R10 second strobe", redirect_o, 1);
      chkv("R4 nested vector", vector_o, 2);
      @(negedge clk);
      chkv("R10 idle", redirect_o, 0);

      // R10: status load ignored when a request is accepted
      ps_wr_en = 1'b1; ps_wr_data = 6'h00; exc_req = 1'b1; exc_cause = 6'd13;
      @(negedge clk);
      ps_wr_en = 1'b0; exc_req = 1'b0;
      chkv("R10 load loses to request", ps_o[4], 1);

      // R1: reset mid-run clears state
      rst_n = 1'b0;
      @(negedge clk);
      chkv("R1 ps after reset", ps_o, 0);
      chkv("R1 depc after reset", depc_o, 0);
      chkv("R1 eps after reset", eps_o, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule